// File: doc/BRIEF.md
# I2C Slave Receiver with Deferred Acknowledge

This block receives write transfers on a two-wire I2C bus as a slave. It brings SCL and SDA into the clock domain through a synchronizer and recognises START and STOP conditions. It compares the first byte with a programmable 7-bit address, shifts in the data bytes that follow, and pulls SDA low to acknowledge. Each received byte is placed in a holding register. A ready flag marks the new byte, an optional counter tallies received bytes, and a completion flag marks the STOP that ends an addressed transfer.

With stretching disabled, every data byte is acknowledged automatically. With stretching enabled, the block holds SCL low after the eighth data bit and raises a byte-finished flag. While the clock is held, the host controller can inspect the byte and set the acknowledge value it wants. Clearing the flag sends that ACK or NAK on the ninth clock. A NAK ends reception until the next START or STOP.

Top module: `i2c_defer_ack_rx`

## Requirements
- R1: SCL and SDA pass through a two-flop synchronizer. SDA falling while SCL is high is a START and restarts address reception. SDA rising while SCL is high is a STOP and returns the block to idle.
- R2: The address byte is sent MSB first. It is acknowledged only when bits 7..1 equal `own_addr_i` and bit 0 (R/W) is 0. Any other address byte leaves SDA released during the ninth clock, and the block ignores the remaining bytes until the next START or STOP.
- R3: `rx_ready_o` rises, and `rx_data_o` takes the byte, on the SCL falling edge after the eighth data bit. A pulse on `rd_ack_i` clears `rx_ready_o`. When setting and clearing fall in the same cycle, setting wins.
- R4: With `stretch_en_i` = 0, every data byte in an addressed transfer is acknowledged by SDA held low through the ninth clock, and `scl_oe_o` is never asserted.
- R5: With `stretch_en_i` = 1, the block asserts `scl_oe_o` (SCL held low) and sets `btf_o` on the SCL falling edge after the eighth data bit. Both stay set until `btf_clr_i` is pulsed, even if the master releases SCL.
- R6: When `btf_clr_i` is pulsed during a stretch, the block drives `ack_val_i` onto SDA in the same cycle (1 = ACK, pulled low; 0 = NAK, released). It releases SCL one cycle later and keeps that SDA value through the ninth clock.
- R7: After a NAK, later bytes are not loaded, not counted and not stretched until the next START or STOP.
- R8: `byte_cnt_o` increments by one (wrapping) for each data byte loaded while `cnt_en_i` = 1. A pulse on `cnt_clr_i` sets it to zero and takes priority over an increment.
- R9: `tcomp_o` is set by a STOP that ends a transfer in which the address matched. It stays set until `tcomp_clr_i` is pulsed. A repeated START does not set it.
- R10: The block asserts `sda_oe_o` only while the synchronized SCL is low.
- R11: After reset, all outputs are 0 and both bus lines are released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe_o | output | 1 | 1 pulls SCL low (stretch) |
| sda_oe_o | output | 1 | 1 pulls SDA low (acknowledge) |
| own_addr_i | input | 7 | Slave address |
| stretch_en_i | input | 1 | Hold SCL after each data byte |
| ack_val_i | input | 1 | Acknowledge value sent after a stretch, 1 = ACK |
| btf_clr_i | input | 1 | Pulse: clear byte-finished flag, end stretch |
| rd_ack_i | input | 1 | Pulse: holding register read, clears ready |
| tcomp_clr_i | input | 1 | Pulse: clear transfer-complete flag |
| cnt_en_i | input | 1 | Enable byte counting |
| cnt_clr_i | input | 1 | Pulse: zero byte counter |
| rx_data_o | output | 8 | Receive holding register |
| rx_ready_o | output | 1 | New byte available |
| btf_o | output | 1 | Byte finished, SCL held |
| tcomp_o | output | 1 | Transfer completed by STOP |
| byte_cnt_o | output | CNT_W | Received byte count |

## Verification
The hardest situation to reach is a stretched ninth clock. The master has already released SCL, the block still holds it low, and the host then turns the stretch into a NAK. The bench model combines master and slave drives as wired-AND lines. A directed task finishes a data byte, releases the master's SCL, and checks for several bit times that the line stays low. It then pulses the clear with each acknowledge value and samples SDA in the ninth clock. A third byte after the NAK confirms that nothing is loaded or stretched.

// File: rtl/i2c_drx_pkg.sv
package i2c_drx_pkg;
  localparam int BYTE_W  = 8;
  localparam int ADDR_W  = BYTE_W - 1;
  localparam int BITCNT_W = $clog2(BYTE_W + 2);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_DATA,
    ST_ACK,
    ST_HOLD,
    ST_REL
  } rx_state_e;
endpackage

// File: rtl/i2c_drx_sync.sv
module i2c_drx_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '1;  // idle bus is high
    else         pipe_q <= {pipe_q[STAGES-2:0], d_i};
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/i2c_drx_cond.sv
module i2c_drx_cond (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_s_i,
  input  logic sda_s_i,
  output logic start_o,
  output logic stop_o,
  output logic scl_rise_o,
  output logic scl_fall_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s_i;
      sda_q <= sda_s_i;
    end
  end

  assign start_o    = scl_s_i & scl_q &  sda_q & ~sda_s_i;
  assign stop_o     = scl_s_i & scl_q & ~sda_q &  sda_s_i;
  assign scl_rise_o = scl_s_i & ~scl_q;
  assign scl_fall_o = ~scl_s_i & scl_q;
endmodule

// File: rtl/i2c_defer_ack_rx.sv
module i2c_defer_ack_rx
  import i2c_drx_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe_o,
  output logic              sda_oe_o,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic              stretch_en_i,
  input  logic              ack_val_i,
  input  logic              btf_clr_i,
  input  logic              rd_ack_i,
  input  logic              tcomp_clr_i,
  input  logic              cnt_en_i,
  input  logic              cnt_clr_i,
  output logic [BYTE_W-1:0] rx_data_o,
  output logic              rx_ready_o,
  output logic              btf_o,
  output logic              tcomp_o,
  output logic [CNT_W-1:0]  byte_cnt_o
);
  localparam logic [BITCNT_W-1:0] LAST_BIT = BITCNT_W'(BYTE_W);
  localparam logic [BITCNT_W-1:0] ACK_BIT  = BITCNT_W'(BYTE_W + 1);

  logic [1:0] sync_q;
  logic scl_s, sda_s;
  logic start, stop, scl_rise, scl_fall;

  rx_state_e           state_q;
  logic [BITCNT_W-1:0] bit_cnt_q;
  logic [BYTE_W-1:0]   shreg_q;
  logic                nak_q, addressed_q;

  i2c_drx_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({scl_i, sda_i}),
    .q_o   (sync_q)
  );
  assign scl_s = sync_q[1];
  assign sda_s = sync_q[0];

  i2c_drx_cond u_cond (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_s_i   (scl_s),
    .sda_s_i   (sda_s),
    .start_o   (start),
    .stop_o    (stop),
    .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      bit_cnt_q   <= '0;
      shreg_q     <= '0;
      nak_q       <= 1'b0;
      addressed_q <= 1'b0;
      sda_oe_o    <= 1'b0;
      scl_oe_o    <= 1'b0;
      rx_data_o   <= '0;
      rx_ready_o  <= 1'b0;
      btf_o       <= 1'b0;
      tcomp_o     <= 1'b0;
      byte_cnt_o  <= '0;
    end else begin
      if (rd_ack_i)    rx_ready_o <= 1'b0;
      if (btf_clr_i)   btf_o      <= 1'b0;
      if (tcomp_clr_i) tcomp_o    <= 1'b0;
      if (cnt_clr_i)   byte_cnt_o <= '0;

      if (start) begin
        state_q   <= ST_ADDR;
        bit_cnt_q <= '0;
        nak_q     <= 1'b0;
        sda_oe_o  <= 1'b0;
        scl_oe_o  <= 1'b0;
      end else if (stop) begin
        state_q     <= ST_IDLE;
        sda_oe_o    <= 1'b0;
        scl_oe_o    <= 1'b0;
        addressed_q <= 1'b0;
        if (addressed_q) tcomp_o <= 1'b1;
      end else begin
        unique case (state_q)
          ST_ADDR, ST_DATA: begin
            if (scl_rise && bit_cnt_q < LAST_BIT) begin
              shreg_q   <= {shreg_q[BYTE_W-2:0], sda_s};
              bit_cnt_q <= bit_cnt_q + 1'b1;
            end else if (scl_fall && bit_cnt_q == LAST_BIT) begin
              if (state_q == ST_ADDR) begin
                if (shreg_q == {own_addr_i, 1'b0}) begin
                  sda_oe_o    <= 1'b1;
                  addressed_q <= 1'b1;
                  nak_q       <= 1'b0;
                  state_q     <= ST_ACK;
                end else begin
                  state_q <= ST_IDLE;
                end
              end else begin
                rx_data_o  <= shreg_q;
                rx_ready_o <= 1'b1;
                if (cnt_en_i && !cnt_clr_i) byte_cnt_o <= byte_cnt_o + 1'b1;
                if (stretch_en_i) begin
                  scl_oe_o <= 1'b1;
                  btf_o    <= 1'b1;
                  state_q  <= ST_HOLD;
                end else begin
                  sda_oe_o <= 1'b1;
                  nak_q    <= 1'b0;
                  state_q  <= ST_ACK;
                end
              end
            end
          end
          ST_HOLD: begin
            // SDA settles one cycle before SCL is let go
            if (btf_clr_i) begin
              sda_oe_o <= ack_val_i;
              nak_q    <= ~ack_val_i;
              state_q  <= ST_REL;
            end
          end
          ST_REL: begin
            scl_oe_o <= 1'b0;
            state_q  <= ST_ACK;
          end
          ST_ACK: begin
            if (scl_rise) begin
              bit_cnt_q <= ACK_BIT;
            end else if (scl_fall && bit_cnt_q == ACK_BIT) begin
              sda_oe_o  <= 1'b0;
              bit_cnt_q <= '0;
              state_q   <= nak_q ? ST_IDLE : ST_DATA;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_drx_chk.sv
module i2c_drx_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             scl_s,
  input logic             sda_oe_o,
  input logic             scl_oe_o,
  input logic             stretch_en_i,
  input logic             btf_o,
  input logic             btf_clr_i,
  input logic             rx_ready_o,
  input logic             tcomp_o,
  input logic             tcomp_clr_i,
  input logic             cnt_clr_i,
  input logic [CNT_W-1:0] byte_cnt_o
);
  assert_sda_drive_scl_low_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> !$past(scl_s));

  assert_no_stretch_when_off_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(scl_oe_o) |-> stretch_en_i);

  assert_btf_with_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(btf_o) |-> scl_oe_o && rx_ready_o);

  assert_btf_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    btf_o && !btf_clr_i |=> btf_o);

  assert_release_after_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(scl_oe_o) |-> !btf_o);

  assert_tcomp_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tcomp_o && !tcomp_clr_i |=> tcomp_o);

  assert_cnt_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_clr_i |=> byte_cnt_o == '0);
endmodule

bind i2c_defer_ack_rx i2c_drx_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .scl_s       (scl_s),
  .sda_oe_o    (sda_oe_o),
  .scl_oe_o    (scl_oe_o),
  .stretch_en_i(stretch_en_i),
  .btf_o       (btf_o),
  .btf_clr_i   (btf_clr_i),
  .rx_ready_o  (rx_ready_o),
  .tcomp_o     (tcomp_o),
  .tcomp_clr_i (tcomp_clr_i),
  .cnt_clr_i   (cnt_clr_i),
  .byte_cnt_o  (byte_cnt_o)
);

// File: tb/i2c_defer_ack_rx_tb.sv
`timescale 1ns/1ps
module i2c_defer_ack_rx_tb;
  localparam int T = 20;
  localparam logic [6:0] OWN = 7'h3A;
  localparam logic [7:0] AW = {OWN, 1'b0};

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic m_scl_low = 1'b0, m_sda_low = 1'b0;
  logic scl_line, sda_line;
  logic scl_oe, sda_oe;
  logic stretch_en = 1'b0, ack_val = 1'b1, btf_clr = 1'b0, rd_ack = 1'b0;
  logic tcomp_clr = 1'b0, cnt_en = 1'b1, cnt_clr = 1'b0;
  logic [7:0] rx_data;
  logic rx_ready, btf, tcomp;
  logic [7:0] byte_cnt;
  int n_chk = 0, n_err = 0, cyc = 0;
  logic got_ack;

  always #2.5 clk = ~clk;
  assign scl_line = !(m_scl_low | scl_oe);
  assign sda_line = !(m_sda_low | sda_oe);

  i2c_defer_ack_rx u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .scl_i(scl_line), .sda_i(sda_line),
    .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .own_addr_i(OWN),
    .stretch_en_i(stretch_en), .ack_val_i(ack_val), .btf_clr_i(btf_clr),
    .rd_ack_i(rd_ack), .tcomp_clr_i(tcomp_clr), .cnt_en_i(cnt_en),
    .cnt_clr_i(cnt_clr), .rx_data_o(rx_data), .rx_ready_o(rx_ready),
    .btf_o(btf), .tcomp_o(tcomp), .byte_cnt_o(byte_cnt)
  );

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual %0d cycles expected < 150000", cyc);
      summary();
    end
  end

  task automatic wt(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic pulse(ref logic s);
    s = 1'b1; wt(1); s = 1'b0;
  endtask

  task automatic bus_start();
    m_sda_low = 1'b1; wt(T); m_scl_low = 1'b1; wt(T);
  endtask

  task automatic bus_rstart();
    m_sda_low = 1'b0; wt(T); m_scl_low = 1'b0; wt(T);
    m_sda_low = 1'b1; wt(T); m_scl_low = 1'b1; wt(T);
  endtask

  task automatic bus_stop();
    m_sda_low = 1'b1; wt(T); m_scl_low = 1'b0; wt(T); m_sda_low = 1'b0; wt(T);
  endtask

  task automatic send_byte(logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      m_sda_low = !b[i]; wt(T);
      m_scl_low = 1'b0;
      do wt(1); while (!scl_line);
      wt(T);
      m_scl_low = 1'b1; wt(T);
    end
  endtask

  // ninth clock; R10: slave SDA must not move while SCL is high
  task automatic ack_clk(output logic ack);
    logic oe_hi;
    m_sda_low = 1'b0; wt(T);
    m_scl_low = 1'b0;
    do wt(1); while (!scl_line);
    wt(T/2);
    ack = !sda_line;
    oe_hi = sda_oe;
    wt(T/2);
    check("R10 sda stable while scl high", sda_oe, oe_hi);
    m_scl_low = 1'b1; wt(T);
  endtask

  task automatic t_reset();
    check("R11 sda_oe", sda_oe, 0);
    check("R11 scl_oe", scl_oe, 0);
    check("R11 rx_ready", rx_ready, 0);
    check("R11 btf", btf, 0);
    check("R11 tcomp", tcomp, 0);
    check("R11 byte_cnt", byte_cnt, 0);
    check("R11 rx_data", rx_data, 0);
  endtask

  task automatic t_auto();
    stretch_en = 1'b0; cnt_en = 1'b1;
    bus_start();
    send_byte(AW); ack_clk(got_ack);
    check("R2 address ack", got_ack, 1);
    send_byte(8'hA5);
    check("R3 rx_data", rx_data, 8'hA5);
    check("R3 rx_ready set", rx_ready, 1);
    check("R4 no stretch", scl_oe, 0);
    ack_clk(got_ack);
    check("R4 auto ack", got_ack, 1);
    pulse(rd_ack); wt(1);
    check("R3 rx_ready cleared", rx_ready, 0);
    send_byte(8'h5C); ack_clk(got_ack);
    check("R4 auto ack 2", got_ack, 1);
    check("R3 rx_data 2", rx_data, 8'h5C);
    check("R8 count 2", byte_cnt, 2);
    check("R9 no tcomp before stop", tcomp, 0);
    bus_stop();
    check("R1 R9 stop sets tcomp", tcomp, 1);
    pulse(tcomp_clr); wt(1);
    check("R9 tcomp cleared", tcomp, 0);
  endtask

  task automatic t_mismatch(logic [7:0] ab, string tag);
    pulse(rd_ack);
    bus_start();
    send_byte(ab); ack_clk(got_ack);
    check({"R2 no ack ", tag}, got_ack, 0);
    send_byte(8'h11); ack_clk(got_ack);
    check({"R2 data ignored ack ", tag}, got_ack, 0);
    check({"R2 data ignored ready ", tag}, rx_ready, 0);
    check({"R2 count unchanged ", tag}, byte_cnt, 2);
    bus_stop();
    check({"R9 no tcomp ", tag}, tcomp, 0);
  endtask

  task automatic t_stretch();
    pulse(cnt_clr); wt(1);
    check("R8 counter cleared", byte_cnt, 0);
    stretch_en = 1'b1;
    bus_start();
    send_byte(AW); ack_clk(got_ack);
    check("R2 address ack stretch", got_ack, 1);
    send_byte(8'h3C);
    check("R5 btf set", btf, 1);
    check("R5 scl held", scl_oe, 1);
    check("R5 rx_data", rx_data, 8'h3C);
    m_sda_low = 1'b0; m_scl_low = 1'b0; wt(3*T);
    check("R5 line stays low", scl_line, 0);
    check("R5 btf still set", btf, 1);
    ack_val = 1'b1;
    pulse(btf_clr);
    check("R6 sda driven first", sda_oe, 1);
    check("R6 scl still held", scl_oe, 1);
    check("R6 btf cleared", btf, 0);
    wt(1);
    check("R6 scl released", scl_oe, 0);
    ack_clk(got_ack);
    check("R6 ack sent", got_ack, 1);
    send_byte(8'h81);
    check("R5 btf 2", btf, 1);
    ack_val = 1'b0;
    pulse(btf_clr); wt(1);
    ack_clk(got_ack);
    check("R6 nak sent", got_ack, 0);
    pulse(rd_ack);
    send_byte(8'h99);
    check("R7 no load", rx_data, 8'h81);
    check("R7 no ready", rx_ready, 0);
    check("R7 no stretch", scl_oe, 0);
    check("R7 no btf", btf, 0);
    ack_clk(got_ack);
    check("R7 no ack", got_ack, 0);
    check("R8 count 2", byte_cnt, 2);
    bus_stop();
    check("R9 tcomp after stretch", tcomp, 1);
    pulse(tcomp_clr);
    ack_val = 1'b1; stretch_en = 1'b0;
  endtask

  task automatic t_rstart();
    cnt_en = 1'b0;
    bus_start();
    send_byte(AW); ack_clk(got_ack);
    send_byte(8'h42); ack_clk(got_ack);
    check("R8 count held when disabled", byte_cnt, 2);
    bus_rstart();
    check("R9 no tcomp on repeated start", tcomp, 0);
    send_byte(AW); ack_clk(got_ack);
    check("R1 readdressed after repeated start", got_ack, 1);
    send_byte(8'h24); ack_clk(got_ack);
    check("R1 data after repeated start", rx_data, 8'h24);
    bus_stop();
    check("R9 tcomp after repeated start", tcomp, 1);
  endtask

  initial begin
    wt(4);
    t_reset();
    rst_ni = 1'b1;
    wt(4);
    t_auto();
    t_mismatch({7'h3B, 1'b0}, "wrong addr");
    t_mismatch({OWN, 1'b1}, "read bit");
    t_stretch();
    t_rstart();
    summary();
  end
endmodule